// File: doc/BRIEF.md
# Truncating Single-Precision Floating-Point Multiplier

This block multiplies two single-precision binary floating-point words and returns their product in the same format. Each operand is split into sign, biased exponent and fraction. The hidden leading one is put back to form a 24-bit significand. The two significands are multiplied by an integer multiplier that is built recursively: each level splits its operands into halves and combines four smaller products, down to a small base block that sums shifted partial products.

The result sign is the exclusive OR of the operand signs. The exponents are added and one bias is removed. The 48-bit significand product is normalized with a shift of at most one place, and the fraction is cut to 23 bits with no rounding. An exponent that leaves the normal range sets an overflow flag, which forces the result to signed infinity, or an underflow flag, which forces it to signed zero. An operand whose exponent field is zero is treated as zero.

The arithmetic is combinational. A single register stage holds the product and the two flags, so a result appears one clock after its operands are presented. Special values are outside the contract: an exponent field of all ones is used as an ordinary number, and a non-zero fraction with a zero exponent is flushed to zero.

Top module: `fpmul_trunc`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `prod`, `ovf` and `unf` to zero.
- R2: The result for the operands present at a rising edge appears on `prod`, `ovf` and `unf` after that edge, and holds until the next edge.
- R3: Bit 31 of a result is the exclusive OR of bit 31 of the two operands, including for zero, infinity and flushed results.
- R4: The word layout is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. When the significand product is below 2.0, the result exponent is Ea + Eb - 127 and the fraction is bits 45:23 of the 48-bit product.
- R5: When bit 47 of the significand product is set, the fraction is product bits 46:24 and the exponent is Ea + Eb - 126.
- R6: Product bits below the kept fraction are discarded without rounding, so the result magnitude is truncated toward zero.
- R7: If either operand has an exponent field of 0, the result is a signed zero (bits 30:0 all zero), with `ovf` and `unf` low.
- R8: If the adjusted exponent is 255 or more, `ovf` is 1 and the result is signed infinity (exponent 255, fraction 0).
- R9: If the adjusted exponent is 0 or less and no operand is zero, `unf` is 1 and the result is signed zero.
- R10: `ovf` and `unf` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand, single-precision word |
| op_b | input | 32 | Second operand, single-precision word |
| prod | output | 32 | Registered product, single-precision word |
| ovf | output | 1 | Registered exponent overflow flag |
| unf | output | 1 | Registered exponent underflow flag |

## Verification
The normalization shift and the range check can act on the same product. A carry into bit 47 adds one to the exponent, and that increment alone can push a result over the top limit or lift it off the bottom limit. The bench provokes this with operand pairs whose exponent sum sits exactly on a limit. Each pair is applied once with significands of 1.0, which gives no carry, and once with significands of 1.5, which gives a carry. It then checks that the flag and the forced value appear only in the case the carry calls for: overflow at 254 plus the carry, and a normal result at 0 plus the carry.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic              is_zero;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
    } fp_parts_t;

    function automatic fp_word_t signed_zero(input logic s);
        fp_word_t w;
        w.sign = s;
        w.exp  = '0;
        w.frac = '0;
        return w;
    endfunction

    function automatic fp_word_t signed_inf(input logic s);
        fp_word_t w;
        w.sign = s;
        w.exp  = EXP_W'(EXP_TOP);
        w.frac = '0;
        return w;
    endfunction

endpackage

// File: rtl/fpmul_unpack.sv
module fpmul_unpack
    import fpmul_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_parts_t         parts
);
    fp_word_t w;

    always_comb begin
        w             = fp_word_t'(word);
        parts.sign    = w.sign;
        parts.exp     = w.exp;
        parts.is_zero = (w.exp == '0);
        parts.sig     = {1'b1, w.frac};
    end
endmodule

// File: rtl/fpmul_sig_mul.sv
module fpmul_sig_mul #(
    parameter int W      = 24,
    parameter int BASE_W = 3
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    generate
        if (W <= BASE_W) begin : g_leaf
            always_comb begin
                p = '0;
                for (int i = 0; i < W; i++) begin
                    if (a[i]) p = p + ({{W{1'b0}}, b} << i);
                end
            end
        end else begin : g_split
            localparam int L = W / 2;
            localparam int H = W - L;

            logic [H-1:0]   a_hi, a_lo, b_hi, b_lo;
            logic [2*H-1:0] pp_hh, pp_hl, pp_lh, pp_ll;
            logic [2*W-1:0] x_hh, x_hl, x_lh, x_ll;

            assign a_hi = a[W-1:L];
            assign b_hi = b[W-1:L];
            assign a_lo = H'(a[L-1:0]);
            assign b_lo = H'(b[L-1:0]);

            fpmul_sig_mul #(.W(H), .BASE_W(BASE_W)) u_hh (.a(a_hi), .b(b_hi), .p(pp_hh));
            fpmul_sig_mul #(.W(H), .BASE_W(BASE_W)) u_hl (.a(a_hi), .b(b_lo), .p(pp_hl));
            fpmul_sig_mul #(.W(H), .BASE_W(BASE_W)) u_lh (.a(a_lo), .b(b_hi), .p(pp_lh));
            fpmul_sig_mul #(.W(H), .BASE_W(BASE_W)) u_ll (.a(a_lo), .b(b_lo), .p(pp_ll));

            assign x_hh = {{(2*W-2*H){1'b0}}, pp_hh};
            assign x_hl = {{(2*W-2*H){1'b0}}, pp_hl};
            assign x_lh = {{(2*W-2*H){1'b0}}, pp_lh};
            assign x_ll = {{(2*W-2*H){1'b0}}, pp_ll};

            assign p = (x_hh << (2 * L)) + ((x_hl + x_lh) << L) + x_ll;
        end
    endgenerate
endmodule

// File: rtl/fpmul_normalize.sv
module fpmul_normalize
    import fpmul_pkg::*;
(
    input  fp_parts_t         pa,
    input  fp_parts_t         pb,
    input  logic [PROD_W-1:0] sig_prod,
    output fp_word_t          result,
    output logic              ovf,
    output logic              unf
);
    logic              carry;
    logic              sgn;
    logic [FRAC_W-1:0] frac;
    logic [PROD_W-1:0] aligned;
    logic              unused_tail;
    int                e_adj;

    assign carry       = sig_prod[PROD_W-1];
    assign sgn         = pa.sign ^ pb.sign;
    assign aligned     = carry ? sig_prod : (sig_prod << 1);
    assign frac        = aligned[PROD_W-2 -: FRAC_W];
    assign unused_tail = ^aligned[PROD_W-2-FRAC_W:0];

    always_comb begin
        e_adj  = int'(pa.exp) + int'(pb.exp) - BIAS + int'(carry);
        ovf    = 1'b0;
        unf    = 1'b0;
        result.sign = sgn;
        result.exp  = e_adj[EXP_W-1:0];
        result.frac = frac;
        if (pa.is_zero || pb.is_zero) begin
            result = signed_zero(sgn);
        end else if (e_adj >= EXP_TOP) begin
            ovf    = 1'b1;
            result = signed_inf(sgn);
        end else if (e_adj <= 0) begin
            unf    = 1'b1;
            result = signed_zero(sgn);
        end
    end
endmodule

// File: rtl/fpmul_trunc.sv
module fpmul_trunc
    import fpmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] prod,
    output logic              ovf,
    output logic              unf
);
    fp_parts_t         pa, pb;
    logic [PROD_W-1:0] sig_prod;
    fp_word_t          res_c;
    logic              ovf_c, unf_c;

    fpmul_unpack u_unpack_a (.word(op_a), .parts(pa));
    fpmul_unpack u_unpack_b (.word(op_b), .parts(pb));

    fpmul_sig_mul #(.W(SIG_W), .BASE_W(3)) u_sig_mul (
        .a (pa.sig),
        .b (pb.sig),
        .p (sig_prod)
    );

    fpmul_normalize u_norm (
        .pa       (pa),
        .pb       (pb),
        .sig_prod (sig_prod),
        .result   (res_c),
        .ovf      (ovf_c),
        .unf      (unf_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else begin
            prod <= res_c;
            ovf  <= ovf_c;
            unf  <= unf_c;
        end
    end
endmodule

// File: rtl/fpmul_trunc_chk.sv
module fpmul_trunc_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [31:0] prod,
    input logic        ovf,
    input logic        unf
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R10
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));

    // R8
    a_r8_ovf_is_inf: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (prod[30:23] == 8'hFF && prod[22:0] == 23'd0));

    // R9
    a_r9_unf_is_zero: assert property (@(posedge clk) disable iff (rst)
        unf |-> (prod[30:0] == 31'd0));

    // R3
    a_r3_sign_xor: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (prod[31] == ($past(op_a[31]) ^ $past(op_b[31]))));

    // R7
    a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ($past(op_a[30:23]) == 8'd0 || $past(op_b[30:23]) == 8'd0))
        |-> (prod[30:0] == 31'd0 && !ovf && !unf));

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (prod == 32'd0 && !ovf && !unf));
endmodule

bind fpmul_trunc fpmul_trunc_chk i_chk (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod),
    .ovf  (ovf),
    .unf  (unf)
);

// File: tb/test_fpmul_trunc.sv
module test_fpmul_trunc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] prod;
    logic        ovf, unf;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fpmul_trunc i_fpmul_trunc (
        .clk  (clk),
        .rst  (rst),
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod),
        .ovf  (ovf),
        .unf  (unf)
    );

    localparam int NVEC = 12;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h3F800000, 32'h3F800000},
        {32'h40490FDB, 32'h402DF854},
        {32'hC1200000, 32'h3DCCCCCD},
        {32'h3FFFFFFF, 32'h3FFFFFFF},
        {32'h12345678, 32'h6789ABCD},
        {32'hBF7FFFFF, 32'hBF800001},
        {32'h7F7FFFFF, 32'h3F800000},
        {32'h7F7FFFFF, 32'h40000000},
        {32'h00800000, 32'h3F800000},
        {32'h00FFFFFF, 32'h3F000000},
        {32'h3E9A1B2C, 32'hC5E4D3C2},
        {32'h80000000, 32'hC2C80000}
    };

    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic        s;
        logic [63:0] p;
        int          e;
        logic [22:0] f;
        s = a[31] ^ b[31];
        if (a[30:23] == 0 || b[30:23] == 0) return {2'b00, s, 31'd0};
        p = {40'd0, 1'b1, a[22:0]} * {40'd0, 1'b1, b[22:0]};
        e = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (p[47]) begin
            f = p[46:24];
            e = e + 1;
        end else begin
            f = p[45:23];
        end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
        if (e <= 0)   return {2'b01, s, 31'd0};
        return {2'b00, s, e[7:0], f};
    endfunction

    task automatic check(input string req, input logic [31:0] exp_p,
                         input logic exp_o, input logic exp_u);
        checks++;
        if (prod !== exp_p || ovf !== exp_o || unf !== exp_u) begin
            errors++;
            $display("FAIL %s: got prod=%h ovf=%b unf=%b, expected prod=%h ovf=%b unf=%b",
                     req, prod, ovf, unf, exp_p, exp_o, exp_u);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [33:0] r;
        op_a = 32'h40000000;
        op_b = 32'h40400000;
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'h0, 1'b0, 1'b0);
        rst = 1'b0;

        // Table walk against the truncating reference (R4, R5, R6, R3)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][63:32], VEC[i][31:0]);
            r = ref_mul(VEC[i][63:32], VEC[i][31:0]);
            check("R4/R5 table vector", r[31:0], r[33], r[32]);
        end

        // R4: 2.0 * 3.0 = 6.0
        apply(32'h40000000, 32'h40400000);
        check("R4 plain product", 32'h40C00000, 1'b0, 1'b0);

        // R2: result holds until the next edge after operands change
        @(negedge clk);
        op_a = 32'h3F800000;
        op_b = 32'h3F800000;
        #1;
        check("R2 held before edge", 32'h40C00000, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 updated after edge", 32'h3F800000, 1'b0, 1'b0);

        // R5: 1.5 * 1.5 = 2.25, carry into bit 47
        apply(32'h3FC00000, 32'h3FC00000);
        check("R5 carry normalize", 32'h40100000, 1'b0, 1'b0);

        // R6: rounding would give 0x40100002
        apply(32'h3FC00001, 32'h3FC00001);
        check("R6 truncation", 32'h40100001, 1'b0, 1'b0);

        // R3: negative times positive
        apply(32'hC0000000, 32'h40400000);
        check("R3 sign xor", 32'hC0C00000, 1'b0, 1'b0);

        // R7: signed zero and a flushed denormal
        apply(32'h80000000, 32'h40000000);
        check("R7 signed zero", 32'h80000000, 1'b0, 1'b0);
        apply(32'h00000001, 32'hFF000000);
        check("R7 denormal flushed", 32'h80000000, 1'b0, 1'b0);

        // R8: exponent sum 254 without carry stays normal, with carry overflows
        apply(32'h5F000000, 32'h5F800000);
        check("R8 top limit no carry", 32'h7F000000, 1'b0, 1'b0);
        apply(32'h5F400000, 32'h5FC00000);
        check("R8 overflow by carry", 32'h7F800000, 1'b1, 1'b0);
        apply(32'hDF400000, 32'h5FC00000);
        check("R8 negative overflow", 32'hFF800000, 1'b1, 1'b0);

        // R9: exponent sum 0 underflows, carry lifts it to exponent 1
        apply(32'h00800000, 32'h3F000000);
        check("R9 underflow", 32'h00000000, 1'b0, 1'b1);
        apply(32'h80800000, 32'h3F000000);
        check("R9 negative underflow", 32'h80000000, 1'b0, 1'b1);
        apply(32'h00C00000, 32'h3F400000);
        check("R9 carry avoids underflow", 32'h00900000, 1'b0, 1'b0);

        // R10: flags exclusive after deep underflow then overflow
        apply(32'h01000000, 32'h01000000);
        check("R10 deep underflow", 32'h00000000, 1'b0, 1'b1);

        // R1: reset in mid-run clears a pending overflow
        apply(32'h7F000000, 32'h7F000000);
        check("R8 large overflow", 32'h7F800000, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 32'h0, 1'b0, 1'b0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule